// File: doc/BRIEF.md
# Register-Bus Pin Controller With Per-Pin Interrupt Triggers

This block drives and senses sixteen general-purpose pins from a simple 32-bit register bus. Three main registers hold pin drive data, pin drive enables and latched interrupt flags. Each main register has two write-only companions. One ORs the write data into the main register and the other clears the bits written as 1. Software can therefore change single bits without a read-modify-write sequence. Sixteen per-pin configuration words choose the interrupt trigger, open-drain behaviour, wake-up participation, and whether the pin is driven from an external sigma-delta bit instead of its data register.

Incoming pad levels pass through a two-flop synchronizer. Edge triggers compare the synchronized level with its value one cycle earlier. Level triggers keep setting their flag as long as the level lasts. Each flag appears on a per-pin request output, and all flags are also ORed into one interrupt line. A separate wake line pulses when a pin with wake-up enabled meets its trigger condition. While reset is held, six pad levels are captured and presented in the upper half of the input word.

Top module: `pio_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the drive-data, drive-enable, status and configuration registers read 0, pad_oe is 0, and irq and wake are 0.
- R2: Byte offsets select the registers: 0x00 drive data, 0x0C drive enable, 0x18 input word, 0x1C status, and 0x28 + 4*n configuration of pin n. A write to 0x00, 0x0C or 0x1C replaces bits 15:0 of that register. A read of any of them returns the register in bits 15:0, with 0 in the upper bits.
- R3: Writes to 0x04, 0x10 and 0x20 OR the write data into drive data, drive enable and status. Writes to 0x08, 0x14 and 0x24 clear the bits given as 1. A read of any of these six offsets returns 0.
- R4: A pin with its enable bit at 1 drives pad_oe high, unless R9 applies, and input word bit n shows its drive value. A pin with its enable bit at 0 has pad_oe low, and input word bit n shows pad_in[n] two clock edges after the pad changes.
- R5: Input word bits 31, 30, 29, 18, 17 and 16 hold pad_in pins 10, 9, 7, 15, 0 and 2 as they were during reset. Input word bits 28:19 read 0.
- R6: Configuration bits 9:7 select the trigger: 1 rising edge, 2 falling edge, 3 either edge. A qualifying pad change sets status bit n on the third clock edge after the change.
- R7: Trigger code 4 (low level) and code 5 (high level) set status bit n on every cycle while the synchronized level matches. A hardware set takes priority over a software clear in the same cycle.
- R8: pin_irq equals status bits 15:0, and irq is 1 exactly when any status bit is 1.
- R9: With configuration bit 2 set, a high drive value deasserts pad_oe for an enabled pin. A low drive value asserts pad_oe with pad_out low.
- R10: With configuration bit 0 set, the pin's drive value is sd_in instead of its drive-data bit.
- R11: With configuration bit 10 set, a trigger hit on that pin pulses wake for one cycle, in the same cycle as the status bit is set. A hit on a pin without bit 10 leaves wake at 0.
- R12: Configuration reads return only bits 0, 2, 9:7 and 10, with all other bits 0. Trigger codes 0, 6 and 7 never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; strapping pads are sampled while it is low |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | Write strobe, used together with bus_en |
| bus_addr | input | 7 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 16 | Pad levels seen from outside |
| sd_in | input | 1 | External sigma-delta bit |
| pad_out | output | 16 | Drive value per pin |
| pad_oe | output | 16 | Drive enable per pin |
| pin_irq | output | 16 | Per-pin interrupt requests |
| irq | output | 1 | OR of all requests |
| wake | output | 1 | Wake-up pulse |

## Verification
Several properties are checked on every cycle:
- software clears never survive unless hardware re-sets the bit in the same cycle;
- a hardware set always lands;
- the strap bits never move outside reset;
- wake never rises without an interrupt;
- a rising-edge hit needs a fresh 0-to-1 history;
- an open-drain pin is never driven high;
- no pin drives while its enable bit is 0.

Only the bench scenarios can show the rest:
- the exact register offsets;
- the alias arithmetic and read-as-zero behaviour;
- the three-edge latency of a trigger;
- that unused trigger codes stay silent;
- the strap mapping;
- that the sigma-delta selection reaches the pad.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int BUS_AW = 7;
  localparam int BUS_DW = 32;
  localparam int WIDX_W = BUS_AW - 2;

  // word indices on the bus
  localparam logic [WIDX_W-1:0] WI_DATA     = 5'd0;
  localparam logic [WIDX_W-1:0] WI_DATA_SET = 5'd1;
  localparam logic [WIDX_W-1:0] WI_DATA_CLR = 5'd2;
  localparam logic [WIDX_W-1:0] WI_EN       = 5'd3;
  localparam logic [WIDX_W-1:0] WI_EN_SET   = 5'd4;
  localparam logic [WIDX_W-1:0] WI_EN_CLR   = 5'd5;
  localparam logic [WIDX_W-1:0] WI_INPUT    = 5'd6;
  localparam logic [WIDX_W-1:0] WI_FLAG     = 5'd7;
  localparam logic [WIDX_W-1:0] WI_FLAG_SET = 5'd8;
  localparam logic [WIDX_W-1:0] WI_FLAG_CLR = 5'd9;
  localparam int CFG_BASE_WI = 10;

  // configuration word field positions
  localparam int CFG_SD_BIT   = 0;
  localparam int CFG_OD_BIT   = 2;
  localparam int CFG_TRIG_LSB = 7;
  localparam int CFG_WAKE_BIT = 10;

  // reset-time capture: input word bit <- pad index
  localparam int STRAP_N = 6;
  localparam int STRAP_IN_BIT [STRAP_N] = '{31, 30, 29, 18, 17, 16};
  localparam int STRAP_PIN    [STRAP_N] = '{10, 9, 7, 15, 0, 2};

  typedef enum logic [2:0] {
    TRG_OFF  = 3'd0,
    TRG_RISE = 3'd1,
    TRG_FALL = 3'd2,
    TRG_BOTH = 3'd3,
    TRG_LOW  = 3'd4,
    TRG_HIGH = 3'd5,
    TRG_RSV6 = 3'd6,
    TRG_RSV7 = 3'd7
  } trig_e;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_SET   = 2'd2,
    UPD_CLR   = 2'd3
  } upd_e;

  typedef struct packed {
    logic  wake_en;
    trig_e trig;
    logic  open_drain;
    logic  sd_sel;
  } pin_cfg_t;

  function automatic logic trig_hit(trig_e mode, logic now, logic prev);
    case (mode)
      TRG_RISE: return now & ~prev;
      TRG_FALL: return ~now & prev;
      TRG_BOTH: return now ^ prev;
      TRG_LOW:  return ~now;
      TRG_HIGH: return now;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic pin_cfg_t cfg_unpack(logic [BUS_DW-1:0] w);
    pin_cfg_t c;
    c.sd_sel     = w[CFG_SD_BIT];
    c.open_drain = w[CFG_OD_BIT];
    c.trig       = trig_e'(w[CFG_TRIG_LSB +: 3]);
    c.wake_en    = w[CFG_WAKE_BIT];
    return c;
  endfunction

  function automatic logic [BUS_DW-1:0] cfg_pack(pin_cfg_t c);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[CFG_SD_BIT]         = c.sd_sel;
    w[CFG_OD_BIT]         = c.open_drain;
    w[CFG_TRIG_LSB +: 3]  = c.trig;
    w[CFG_WAKE_BIT]       = c.wake_en;
    return w;
  endfunction

  // open-drain: a high value releases the pad
  function automatic logic drive_enable(logic en, logic od, logic val);
    return en & ~(od & val);
  endfunction

  function automatic logic drive_level(logic od, logic val);
    return val & ~od;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] now,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      now    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= d;
      now    <= stage1;
      prev   <= now;
    end
  end

endmodule

// File: rtl/pio_trigger.sv
module pio_trigger
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIN_COUNT-1:0]     now,
  input  logic [PIN_COUNT-1:0]     prev,
  input  pin_cfg_t [PIN_COUNT-1:0] cfg,
  output logic [PIN_COUNT-1:0]     hit,
  output logic                     wake_q
);

  logic [PIN_COUNT-1:0] wake_hit;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    assign hit[i]      = trig_hit(cfg[i].trig, now[i], prev[i]);
    assign wake_hit[i] = hit[i] & cfg[i].wake_en;

    // R6: a rising-edge hit needs the level one cycle ago to be 0
    a_r6_rise_history: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i].trig == TRG_RISE && hit[i]) |-> (now[i] && !$past(now[i])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |wake_hit;
  end

endmodule

// File: rtl/pio_pindrive.sv
module pio_pindrive
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIN_COUNT-1:0]     data_q,
  input  logic [PIN_COUNT-1:0]     en_q,
  input  pin_cfg_t [PIN_COUNT-1:0] cfg,
  input  logic                     sd_in,
  output logic [PIN_COUNT-1:0]     value,
  output logic [PIN_COUNT-1:0]     pad_out,
  output logic [PIN_COUNT-1:0]     pad_oe
);

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    assign value[i]   = cfg[i].sd_sel ? sd_in : data_q[i];
    assign pad_oe[i]  = drive_enable(en_q[i], cfg[i].open_drain, value[i]);
    assign pad_out[i] = drive_level(cfg[i].open_drain, value[i]);

    // R4: no drive without the enable bit
    a_r4_oe_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[i] |-> en_q[i]);
    // R9: an open-drain pin never drives high
    a_r9_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i].open_drain && pad_oe[i]) |-> !pad_out[i]);
  end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  input  logic                 sd_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pin_irq,
  output logic                 irq,
  output logic                 wake
);

  localparam int PW = PIN_COUNT;

  function automatic logic [PW-1:0] apply_upd(logic [PW-1:0] cur, logic [PW-1:0] d, upd_e op);
    case (op)
      UPD_WRITE: return d;
      UPD_SET:   return cur | d;
      UPD_CLR:   return cur & ~d;
      default:   return cur;
    endcase
  endfunction

  logic [WIDX_W-1:0] widx;
  logic              wr;
  logic [PW-1:0]     wd;
  upd_e              data_upd, en_upd, flag_upd;

  logic [PW-1:0]     data_q, en_q, flag_q;
  logic [PW-1:0]     flag_sw_next, sw_clr_mask;
  pin_cfg_t [PW-1:0] cfg_q;
  logic [PW-1:0]     cfg_sel;
  logic [STRAP_N-1:0] strap_q;

  logic [PW-1:0]     s_now, s_prev, hw_hit, drv_value;
  logic [PW-1:0]     in_low;
  logic [BUS_DW-1:0] in_word;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_DW-1:PW]};

  assign widx = bus_addr[BUS_AW-1:2];
  assign wr   = bus_en & bus_we;
  assign wd   = bus_wdata[PW-1:0];

  always_comb begin
    data_upd = UPD_NONE;
    en_upd   = UPD_NONE;
    flag_upd = UPD_NONE;
    if (wr) begin
      case (widx)
        WI_DATA:     data_upd = UPD_WRITE;
        WI_DATA_SET: data_upd = UPD_SET;
        WI_DATA_CLR: data_upd = UPD_CLR;
        WI_EN:       en_upd   = UPD_WRITE;
        WI_EN_SET:   en_upd   = UPD_SET;
        WI_EN_CLR:   en_upd   = UPD_CLR;
        WI_FLAG:     flag_upd = UPD_WRITE;
        WI_FLAG_SET: flag_upd = UPD_SET;
        WI_FLAG_CLR: flag_upd = UPD_CLR;
        default:     ;
      endcase
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_cfg_sel
    assign cfg_sel[i] = wr && (widx == WIDX_W'(CFG_BASE_WI + i));
  end

  // software update first, hardware hits ORed on top
  assign flag_sw_next = apply_upd(flag_q, wd, flag_upd);
  assign sw_clr_mask  = (flag_upd == UPD_CLR)   ? wd  :
                        (flag_upd == UPD_WRITE) ? ~wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
      cfg_q  <= '0;
    end else begin
      data_q <= apply_upd(data_q, wd, data_upd);
      en_q   <= apply_upd(en_q, wd, en_upd);
      flag_q <= flag_sw_next | hw_hit;
      for (int i = 0; i < PW; i++)
        if (cfg_sel[i]) cfg_q[i] <= cfg_unpack(bus_wdata);
    end
  end

  // reset-time pad capture
  always_ff @(posedge clk) begin
    if (!rst_n)
      for (int k = 0; k < STRAP_N; k++) strap_q[k] <= pad_in[STRAP_PIN[k]];
  end

  pio_sync #(.WIDTH(PW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .now  (s_now),
    .prev (s_prev)
  );

  pio_trigger #(.PIN_COUNT(PW)) u_trigger (
    .clk   (clk),
    .rst_n (rst_n),
    .now   (s_now),
    .prev  (s_prev),
    .cfg   (cfg_q),
    .hit   (hw_hit),
    .wake_q(wake)
  );

  pio_pindrive #(.PIN_COUNT(PW)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_q (data_q),
    .en_q   (en_q),
    .cfg    (cfg_q),
    .sd_in  (sd_in),
    .value  (drv_value),
    .pad_out(pad_out),
    .pad_oe (pad_oe)
  );

  assign in_low = (en_q & drv_value) | (~en_q & s_now);

  always_comb begin
    in_word = '0;
    in_word[PW-1:0] = in_low;
    for (int k = 0; k < STRAP_N; k++) in_word[STRAP_IN_BIT[k]] = strap_q[k];
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      WI_DATA:  bus_rdata[PW-1:0] = data_q;
      WI_EN:    bus_rdata[PW-1:0] = en_q;
      WI_INPUT: bus_rdata = in_word;
      WI_FLAG:  bus_rdata[PW-1:0] = flag_q;
      default:  ;
    endcase
    for (int i = 0; i < PW; i++)
      if (widx == WIDX_W'(CFG_BASE_WI + i)) bus_rdata = cfg_pack(cfg_q[i]);
  end

  assign pin_irq = flag_q;
  assign irq     = |flag_q;

  // R8: a software clear sticks unless hardware re-sets the same bit
  a_r8_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr_mask & ~hw_hit)) |=> ((flag_q & $past(sw_clr_mask & ~hw_hit)) == '0));
  // R7: a hardware set always lands, whatever software does
  a_r7_hw_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_hit) |=> ((flag_q & $past(hw_hit)) == $past(hw_hit)));
  // R5: captured strap values do not move after reset
  a_r5_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
  // R11: wake comes with a set interrupt flag
  a_r11_wake_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq);

endmodule

// File: tb/test_pio_ctrl.sv
module test_pio_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = 16'h8484;
  logic        sd_in = 1'b0;
  logic [15:0] pad_out, pad_oe, pin_irq;
  logic        irq, wake;

  int n_checks = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_ctrl i_pio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .sd_in(sd_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_irq(pin_irq), .irq(irq), .wake(wake)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_check(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    check("R1 pad_oe", {16'h0, pad_oe}, 0);
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 wake", {31'h0, wake}, 0);
    rd_check("R1 data", 7'h00, 0);
    rd_check("R1 enable", 7'h0C, 0);
    rd_check("R1 status", 7'h1C, 0);
    rd_check("R1 cfg0", 7'h28, 0);
    cycles(3);
    rd_check("R5 strap word", 7'h18, 32'hA005_0000);
  endtask

  task automatic t_regs;
    wr(7'h00, 32'hFFFF_1234);
    rd_check("R2 data write", 7'h00, 32'h1234);
    wr(7'h0C, 32'h00FF);
    check("R2 pad_oe", {16'h0, pad_oe}, 32'h00FF);
    check("R2 pad_out", {16'h0, pad_out}, 32'h1234);
    wr(7'h04, 32'h8001);
    rd_check("R3 data set", 7'h00, 32'h9235);
    rd_check("R3 set alias reads 0", 7'h04, 0);
    wr(7'h08, 32'h0204);
    rd_check("R3 data clear", 7'h00, 32'h9031);
    rd_check("R3 clear alias reads 0", 7'h08, 0);
    wr(7'h14, 32'h000F);
    rd_check("R3 enable clear", 7'h0C, 32'h00F0);
    wr(7'h10, 32'h000F);
    rd_check("R3 enable set", 7'h0C, 32'h00FF);
    rd_check("R3 enable clear alias reads 0", 7'h14, 0);
  endtask

  task automatic t_input;
    pad_in = 16'hAB00;
    cycles(2);
    rd_check("R4 input word mixed", 7'h18, 32'hA005_AB31);
    wr(7'h0C, 0);
    check("R4 oe off", {16'h0, pad_oe}, 0);
    wr(7'h00, 0);
    pad_in = 16'h0000;
    cycles(3);
    rd_check("R4 input word idle", 7'h18, 32'hA005_0000);
  endtask

  task automatic t_edges;
    wr(7'h34, 32'h80);              // pin 3 rising
    pad_in[3] = 1;
    cycles(2);
    rd_check("R6 not yet at edge 2", 7'h1C, 0);
    cycles(1);
    rd_check("R6 rise sets", 7'h1C, 32'h8);
    check("R8 pin_irq", {16'h0, pin_irq}, 32'h8);
    check("R8 irq", {31'h0, irq}, 1);
    wr(7'h24, 32'h8);
    rd_check("R8 clear alias", 7'h1C, 0);
    check("R8 irq low", {31'h0, irq}, 0);
    pad_in[3] = 0;
    cycles(4);
    rd_check("R6 rise ignores fall", 7'h1C, 0);
    wr(7'h34, 32'h100);             // falling
    pad_in[3] = 1;
    cycles(4);
    rd_check("R6 fall ignores rise", 7'h1C, 0);
    pad_in[3] = 0;
    cycles(3);
    rd_check("R6 fall sets", 7'h1C, 32'h8);
    wr(7'h1C, 0);
    rd_check("R8 direct clear", 7'h1C, 0);
    wr(7'h34, 32'h180);             // either edge
    pad_in[3] = 1;
    cycles(3);
    rd_check("R6 both rise", 7'h1C, 32'h8);
    wr(7'h24, 32'h8);
    pad_in[3] = 0;
    cycles(3);
    rd_check("R6 both fall", 7'h1C, 32'h8);
    wr(7'h24, 32'h8);
    wr(7'h34, 0);
    wr(7'h20, 32'h4000);
    rd_check("R3 status set alias", 7'h1C, 32'h4000);
    check("R8 irq from set", {31'h0, irq}, 1);
    wr(7'h24, 32'h4000);
    rd_check("R3 status cleared", 7'h1C, 0);
  endtask

  task automatic t_levels;
    wr(7'h3C, 32'h280);             // pin 5 high level
    pad_in[5] = 1;
    cycles(3);
    rd_check("R7 high sets", 7'h1C, 32'h20);
    wr(7'h24, 32'h20);
    rd_check("R7 hw beats clear", 7'h1C, 32'h20);
    pad_in[5] = 0;
    cycles(3);
    wr(7'h24, 32'h20);
    cycles(2);
    rd_check("R7 high gone stays clear", 7'h1C, 0);
    wr(7'h40, 32'h200);             // pin 6 low level, pad already low
    cycles(1);
    rd_check("R7 low sets", 7'h1C, 32'h40);
    pad_in[6] = 1;
    cycles(3);
    wr(7'h24, 32'h40);
    cycles(2);
    rd_check("R7 low gone stays clear", 7'h1C, 0);
    wr(7'h3C, 0);
    wr(7'h40, 0);
    pad_in[6] = 0;
    cycles(3);
  endtask

  task automatic t_cfg;
    wr(7'h38, 32'hFFFF_FFFF);
    rd_check("R12 cfg readback", 7'h38, 32'h0000_0785);
    wr(7'h38, 0);
    rd_check("R12 cfg cleared", 7'h38, 0);
    wr(7'h2C, 32'h300);             // pin 1 code 6
    pad_in[1] = 1;
    cycles(4);
    pad_in[1] = 0;
    cycles(4);
    rd_check("R12 code 6 silent", 7'h1C, 0);
    wr(7'h2C, 32'h380);             // code 7
    pad_in[1] = 1;
    cycles(4);
    rd_check("R12 code 7 silent", 7'h1C, 0);
    wr(7'h2C, 0);
    pad_in[1] = 0;
    cycles(3);
  endtask

  task automatic t_drive;
    wr(7'h10, 32'h100);             // enable pin 8
    wr(7'h48, 32'h4);               // open drain
    wr(7'h04, 32'h100);
    check("R9 high releases", {31'h0, pad_oe[8]}, 0);
    wr(7'h08, 32'h100);
    check("R9 low drives oe", {31'h0, pad_oe[8]}, 1);
    check("R9 low drives 0", {31'h0, pad_out[8]}, 0);
    wr(7'h48, 0);
    wr(7'h04, 32'h100);
    check("R4 push-pull high oe", {31'h0, pad_oe[8]}, 1);
    check("R4 push-pull high out", {31'h0, pad_out[8]}, 1);
    wr(7'h10, 32'h200);             // enable pin 9
    wr(7'h4C, 32'h1);               // sigma-delta source
    sd_in = 1;
    #1 check("R10 sd high", {31'h0, pad_out[9]}, 1);
    rd_check("R10 input word", 7'h18, 32'hA005_0300);
    @(negedge clk);
    wr(7'h04, 32'h200);
    sd_in = 0;
    #1 check("R10 sd low over data", {31'h0, pad_out[9]}, 0);
    @(negedge clk);
    wr(7'h4C, 0);
    wr(7'h0C, 0);
    wr(7'h00, 0);
  endtask

  task automatic t_wake;
    wr(7'h54, 32'h480);             // pin 11 rise + wake
    pad_in[11] = 1;
    cycles(2);
    check("R11 wake not yet", {31'h0, wake}, 0);
    cycles(1);
    check("R11 wake pulse", {31'h0, wake}, 1);
    rd_check("R11 status with wake", 7'h1C, 32'h800);
    cycles(1);
    check("R11 wake one cycle", {31'h0, wake}, 0);
    wr(7'h24, 32'h800);
    wr(7'h58, 32'h80);              // pin 12 rise, no wake
    pad_in[12] = 1;
    cycles(3);
    check("R11 no wake without enable", {31'h0, wake}, 0);
    rd_check("R11 status pin 12", 7'h1C, 32'h1000);
    wr(7'h24, 32'h1000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    pad_in = 16'h0000;
    t_reset();
    t_regs();
    t_input();
    t_edges();
    t_levels();
    t_cfg();
    t_drive();
    t_wake();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule